// File: doc/BRIEF.md
# Configurable Serial Receiver with Receive Queue

This block recovers characters from a single asynchronous serial input. Bit timing comes from an external sample tick that runs at sixteen times the bit rate. The receiver confirms each start bit at its midpoint and then samples every following bit at mid-bit. Runtime inputs set the word length (5 to 8 bits), whether a parity bit is present and which sense it uses, the order in which data bits arrive, and whether the idle line level is high or low.

Each finished character goes into a 16-entry first-in first-out queue. A host pops the queue through a read strobe and sees the oldest character on a show-ahead data output. Three status flags are sticky: queue overflow, parity mismatch and line fault (a stop bit found at the space level). Only a reset clears them. A data interrupt follows queue occupancy, and an error interrupt follows the sticky flags. A status word shows the current receiver state code next to the queue fill level.

Top module: `serin_rx`

## Requirements
- R1: The 2-bit `cfg_len` value selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Each stored character is right-aligned in 8 bits, and the bits above the word length read as zero.
- R2: With `cfg_msb_first` at 0, the first data bit received becomes bit 0 of the character. With `cfg_msb_first` at 1, the first data bit received becomes the highest bit of the word length.
- R3: With `cfg_active_low` at 0, the idle (mark) level is a high `rx_line`. With `cfg_active_low` at 1, the line is inverted and the idle level is low. Both settings yield the same characters.
- R4: The queue holds up to 16 characters and returns them in arrival order. `rx_level` reports 0 to 16, and `rx_not_empty` is 1 exactly when `rx_level` is nonzero.
- R5: With `cfg_par_en` at 1, a parity bit follows the data. With `cfg_par_even` at 1 the data ones plus the parity bit must be even, and at 0 they must be odd. A mismatch sets `err_parity`, and the character is still stored.
- R6: A stop bit sampled at the space level sets `err_line`, and that character is not stored. This covers a line held at space.
- R7: A character that completes while the queue holds 16 entries is dropped, sets `err_overflow`, and leaves the queued contents unchanged.
- R8: The three error flags stay set until `rst_n` is asserted, and popping does not clear them. `irq_err` equals `irq_en[2]` AND any error flag.
- R9: `irq_data` equals `irq_en[0]` AND `rx_not_empty`, so popping the last queued character clears it.
- R10: `irq_en[1]` belongs to the transmit side and has no effect on either interrupt output.
- R11: In `rx_status`, bits 3:0 hold the state code and bits 12:8 hold the fill level, with bits 7:4 at zero. The state codes are 0 idle, 1 start check, 7 waiting for the next bit, 2 taking a data bit, 8 checking parity, 9 waiting for stop after parity, 4 waiting for stop without parity, and 10 storing.
- R12: A space pulse that is gone at the start-bit midpoint (8 ticks after detection) returns the receiver to idle. Nothing is stored and no flag is set.
- R13: A read strobe while the queue is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears queue and flags |
| sample_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_line | input | 1 | Serial input |
| cfg_len | input | 2 | Word length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 even parity, 0 odd |
| cfg_msb_first | input | 1 | Data bit order |
| cfg_active_low | input | 1 | Line polarity |
| irq_en | input | 3 | Interrupt enables: bit 0 data, bit 1 transmit (unused), bit 2 error |
| rd_pop | input | 1 | Pop the oldest character |
| rd_data | output | 8 | Oldest queued character, 0 when empty |
| rx_not_empty | output | 1 | Queue holds data |
| rx_level | output | 5 | Queue fill level |
| rx_status | output | 13 | State code and fill level |
| err_overflow | output | 1 | Sticky overflow flag |
| err_parity | output | 1 | Sticky parity flag |
| err_line | output | 1 | Sticky line-fault flag |
| irq_data | output | 1 | Data interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Overflow is the hardest case to reach, because it needs seventeen complete frames with no pop in between. The stimulus sends all seventeen back to back and then drains the queue, checking that the first sixteen values come out in order and that the seventeenth is gone. The one-cycle state codes (2, 8 and 10) are reached by recording every code seen on each clock during one frame with parity and one frame without. The line fault is produced by holding the line at space for many bit times.

// File: rtl/serin_pkg.sv
package serin_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_START = 4'd1,
    ST_DATA  = 4'd2,
    ST_STOP  = 4'd4,
    ST_WAIT  = 4'd7,
    ST_PCHK  = 4'd8,
    ST_PWAIT = 4'd9,
    ST_STORE = 4'd10
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic       msb_first;
  } rx_cfg_t;

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return 4'(len) + 4'd5;
  endfunction

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  // LSb-first frames shift in from the top; MSb-first frames from the bottom.
  function automatic logic [7:0] align_word(input logic [7:0] sh, input logic [1:0] len,
                                            input logic msb_first);
    if (msb_first) return sh & len_mask(len);
    return sh >> (2'd3 - len);
  endfunction

  function automatic logic parity_ok(input logic [7:0] word, input logic pbit,
                                     input logic even);
    return ((^word) ^ pbit) != even;
  endfunction

endpackage

// File: rtl/serin_sync.sv
module serin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serin_frame.sv
module serin_frame
  import serin_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_mark,
  input  rx_cfg_t    cfg,
  output rx_state_e  state_o,
  output logic       push_o,
  output logic [7:0] word_o,
  output logic       par_err_o,
  output logic       line_err_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  rx_state_e   st;
  logic [CW-1:0] tcnt;
  logic [3:0]  bcnt;
  logic [7:0]  shreg;
  logic [3:0]  nbits;
  logic        bit_end;

  assign nbits      = data_bits(cfg.len);
  assign bit_end    = tick && (tcnt == LAST);
  assign word_o     = align_word(shreg, cfg.len, cfg.msb_first);
  assign push_o     = (st == ST_STORE);
  assign par_err_o  = (st == ST_PCHK) && !parity_ok(word_o, line_mark, cfg.par_even);
  assign line_err_o = ((st == ST_STOP) || (st == ST_PWAIT)) && bit_end && !line_mark;
  assign state_o    = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      tcnt  <= '0;
      bcnt  <= '0;
      shreg <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (tick && !line_mark) begin
            st    <= ST_START;
            tcnt  <= '0;
            bcnt  <= '0;
            shreg <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (tcnt == MID) begin
              tcnt <= '0;
              st   <= line_mark ? ST_IDLE : ST_WAIT;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (tick) begin
            if (tcnt == LAST) begin
              tcnt <= '0;
              st   <= (bcnt == nbits) ? ST_PCHK : ST_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          shreg <= cfg.msb_first ? {shreg[6:0], line_mark} : {line_mark, shreg[7:1]};
          bcnt  <= bcnt + 4'd1;
          if (bcnt + 4'd1 == nbits) st <= cfg.par_en ? ST_WAIT : ST_STOP;
          else                      st <= ST_WAIT;
        end
        ST_PCHK: st <= ST_PWAIT;
        ST_STOP, ST_PWAIT: begin
          if (tick) begin
            if (tcnt == LAST) begin
              tcnt <= '0;
              st   <= line_mark ? ST_STORE : ST_IDLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_STORE: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serin_fifo.sv
module serin_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);
  assign head    = (count == '0) ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/serin_rx.sv
module serin_rx
  import serin_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LW          = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic          rx_line,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_even,
  input  logic          cfg_msb_first,
  input  logic          cfg_active_low,
  input  logic [2:0]    irq_en,
  input  logic          rd_pop,
  output logic [7:0]    rd_data,
  output logic          rx_not_empty,
  output logic [LW-1:0] rx_level,
  output logic [LW+7:0] rx_status,
  output logic          err_overflow,
  output logic          err_parity,
  output logic          err_line,
  output logic          irq_data,
  output logic          irq_err
);
  rx_cfg_t   cfg;
  rx_state_e st;
  logic       line_mark;
  logic       push_evt, par_evt, line_evt, fifo_full;
  logic [7:0] word;
  logic [3:0] st_code;

  assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_even: cfg_par_even,
                 msb_first: cfg_msb_first};

  serin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line ^ cfg_active_low), .q(line_mark)
  );

  serin_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .line_mark(line_mark), .cfg(cfg),
    .state_o(st), .push_o(push_evt), .word_o(word), .par_err_o(par_evt),
    .line_err_o(line_evt)
  );

  serin_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .wdata(word), .pop(rd_pop),
    .head(rd_data), .full(fifo_full), .count(rx_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_overflow <= 1'b0;
      err_parity   <= 1'b0;
      err_line     <= 1'b0;
    end else begin
      if (push_evt && fifo_full) err_overflow <= 1'b1;
      if (par_evt)               err_parity   <= 1'b1;
      if (line_evt)              err_line     <= 1'b1;
    end
  end

  assign st_code      = 4'(st);
  assign rx_not_empty = (rx_level != '0);
  assign rx_status    = {rx_level, 4'b0000, st_code};
  assign irq_data     = irq_en[0] && rx_not_empty;
  assign irq_err      = irq_en[2] && (err_overflow || err_parity || err_line);
endmodule

// File: rtl/serin_rx_chk.sv
module serin_rx_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    state,
  input logic          push,
  input logic          full,
  input logic          rd_pop,
  input logic [LW-1:0] level,
  input logic          err_ovf,
  input logic          err_par,
  input logic          err_line
);
  assert_level_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_level_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(level)) || (level == $past(level) + 1'b1) ||
             (level + 1'b1 == $past(level)));

  assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> err_ovf);

  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !rd_pop) |=> (level == LW'(DEPTH)));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |=> err_ovf);

  assert_par_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_par |=> err_par);

  assert_line_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_line |=> err_line);

  assert_pop_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && level == '0 && !push) |=> (level == '0));

  assert_state_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd0) || (state == 4'd1) || (state == 4'd2) || (state == 4'd4) ||
    (state == 4'd7) || (state == 4'd8) || (state == 4'd9) || (state == 4'd10));

  assert_push_from_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (state == 4'd10));

  assert_store_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd10) |=> (state == 4'd0));
endmodule

bind serin_rx serin_rx_chk #(.DEPTH(DEPTH), .LW(LW)) i_chk (
  .clk(clk), .rst_n(rst_n), .state(st_code), .push(push_evt), .full(fifo_full),
  .rd_pop(rd_pop), .level(rx_level), .err_ovf(err_overflow), .err_par(err_parity),
  .err_line(err_line)
);

// File: tb/test_serin_rx.sv
module test_serin_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_tick = 1'b0;
  logic        rx_line = 1'b1;
  logic [1:0]  cfg_len = 2'd3;
  logic        cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_msb_first = 1'b0;
  logic        cfg_active_low = 1'b0;
  logic [2:0]  irq_en = 3'b101;
  logic        rd_pop = 1'b0;
  logic [7:0]  rd_data;
  logic        rx_not_empty;
  logic [4:0]  rx_level;
  logic [12:0] rx_status;
  logic        err_overflow, err_parity, err_line, irq_data, irq_err;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] seen = '0;
  logic        trace_on = 1'b0;
  logic        status_bad = 1'b0;

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    sample_tick = ~sample_tick;
  end

  serin_rx i_serin_rx (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_msb_first(cfg_msb_first), .cfg_active_low(cfg_active_low), .irq_en(irq_en),
    .rd_pop(rd_pop), .rd_data(rd_data), .rx_not_empty(rx_not_empty),
    .rx_level(rx_level), .rx_status(rx_status), .err_overflow(err_overflow),
    .err_parity(err_parity), .err_line(err_line), .irq_data(irq_data), .irq_err(irq_err)
  );

  // R11 layout monitor: code in 3:0, zeros in 7:4, level in 12:8
  always @(negedge clk) begin
    if (trace_on) seen[rx_status[3:0]] <= 1'b1;
    if (rst_n && (rx_status[7:4] != 4'd0 || rx_status[12:8] != rx_level)) status_bad <= 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic mark);
    rx_line = mark ^ cfg_active_low;
  endtask

  task automatic bit_out(input logic mark);
    drive(mark);
    repeat (32) @(negedge clk);
  endtask

  task automatic do_reset();
    drive(1'b1);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    int n;
    logic [7:0] m;
    logic p;
    n = int'(cfg_len) + 5;
    m = 8'hFF >> (3 - int'(cfg_len));
    bit_out(1'b0);
    for (int i = 0; i < n; i++) bit_out(cfg_msb_first ? d[n-1-i] : d[i]);
    if (cfg_par_en) begin
      p = ^(d & m);
      bit_out((cfg_par_even ? p : ~p) ^ bad_par);
    end
    bit_out(~bad_stop);
    bit_out(1'b1);
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d1, d2, m;
    do_reset();
    // Reset state (R4, R8, R9, R11)
    check("R4 reset level", rx_level, 0);
    check("R4 reset not_empty", rx_not_empty, 0);
    check("R11 reset status", rx_status, 0);
    check("R8 reset flags", {err_overflow, err_parity, err_line, irq_err}, 0);
    check("R9 reset irq_data", irq_data, 0);

    // R13: pop while empty
    pop();
    check("R13 empty pop level", rx_level, 0);
    check("R13 empty pop data", rd_data, 0);

    // Sweep all configurations: R1 R2 R3 R5 R4
    for (int c = 0; c < 64; c++) begin
      cfg_len        = c[1:0];
      cfg_par_en     = c[2];
      cfg_par_even   = c[3];
      cfg_msb_first  = c[4];
      cfg_active_low = c[5];
      drive(1'b1);
      repeat (8) @(negedge clk);
      m  = 8'hFF >> (3 - c[1:0]);
      d1 = 8'(c * 37 + 5);
      d2 = ~d1;
      send(d1, 1'b0, 1'b0);
      send(d2, 1'b0, 1'b0);
      check("R4 sweep level two", rx_level, 2);
      check("R1 R2 R3 first char", rd_data, d1 & m);
      pop();
      check("R1 R2 R3 second char", rd_data, d2 & m);
      pop();
      check("R4 sweep drained", rx_level, 0);
      check("R5 sweep no errors", {err_overflow, err_parity, err_line}, 0);
    end
    cfg_active_low = 1'b0;
    check("R11 status layout", status_bad, 0);

    // R11 state trace, parity frame
    cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_msb_first = 1'b0;
    do_reset();
    seen = '0; trace_on = 1'b1;
    send(8'h5A, 1'b0, 1'b0);
    trace_on = 1'b0;
    check("R11 codes with parity", seen, 16'h0787);
    pop();
    // R11 state trace, no parity
    cfg_par_en = 1'b0;
    seen = '0; trace_on = 1'b1;
    send(8'h33, 1'b0, 1'b0);
    trace_on = 1'b0;
    check("R11 codes without parity", seen, 16'h0497);
    pop();

    // R12 false start
    seen = '0; trace_on = 1'b1;
    drive(1'b0);
    repeat (8) @(negedge clk);
    drive(1'b1);
    repeat (64) @(negedge clk);
    trace_on = 1'b0;
    check("R12 no wait state", seen[7], 0);
    check("R12 start seen", seen[1], 1);
    check("R12 nothing stored", rx_level, 0);
    check("R12 no flags", {err_overflow, err_parity, err_line}, 0);
    check("R12 back to idle", rx_status[3:0], 0);

    // R9 R10 interrupt enables
    send(8'hC3, 1'b0, 1'b0);
    irq_en = 3'b010;
    @(negedge clk);
    check("R10 tx enable no data irq", irq_data, 0);
    irq_en = 3'b001;
    @(negedge clk);
    check("R9 data irq", irq_data, 1);
    pop();
    check("R9 data irq cleared by pop", irq_data, 0);

    // R5 parity error: stored, sticky, irq
    irq_en = 3'b101;
    cfg_par_en = 1'b1; cfg_par_even = 1'b0;
    do_reset();
    send(8'h3C, 1'b1, 1'b0);
    check("R5 parity flag", err_parity, 1);
    check("R5 char kept", rd_data, 8'h3C);
    check("R8 err irq", irq_err, 1);
    check("R5 no line flag", err_line, 0);
    pop();
    check("R8 flag survives pop", err_parity, 1);
    check("R8 irq survives pop", irq_err, 1);
    irq_en = 3'b011;
    @(negedge clk);
    check("R8 err irq masked", irq_err, 0);
    check("R10 tx enable no err irq", irq_err, 0);
    irq_en = 3'b101;

    // R6 line held at space
    cfg_par_en = 1'b0;
    do_reset();
    drive(1'b0);
    repeat (12 * 32) @(negedge clk);
    drive(1'b1);
    repeat (64) @(negedge clk);
    check("R6 line flag", err_line, 1);
    check("R6 nothing stored", rx_level, 0);
    check("R6 err irq", irq_err, 1);
    send(8'hAA, 1'b0, 1'b1);
    check("R6 bad stop dropped", rx_level, 0);
    do_reset();
    check("R8 reset clears line flag", err_line, 0);

    // R7 overflow
    for (int i = 0; i < 17; i++) send(8'(i * 11 + 1), 1'b0, 1'b0);
    check("R7 level full", rx_level, 16);
    check("R7 overflow flag", err_overflow, 1);
    check("R7 err irq", irq_err, 1);
    for (int i = 0; i < 16; i++) begin
      check("R4 R7 order", rd_data, (i * 11 + 1) & 8'hFF);
      pop();
    end
    check("R7 extra char dropped", rx_level, 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule